// File: doc/BRIEF.md
# Partial-Bypass Operand Forwarding and Stall Unit

This unit sits at the operand-read stage of an in-order pipeline with the stages fetch, decode, operand read, first execute, second execute and write-back. For each source operand port it compares the requested register against the destination registers of the instructions still in flight in the later stages. Each producer stage is called a source. Sources are numbered from the youngest: 0 is the first execute stage, 1 is the second execute stage and 2 is write-back. A value can be taken from a source only through a path that is switched on in a static grid. The grid has one enable bit for each pairing of a producing source with an operand port.

When the youngest in-flight writer of a register can deliver its result through an enabled path, the unit forwards that result without delay. When that writer can reach the operand only through a removed path, or its result is not computed yet, the unit raises a stall. Surrounding control uses the stall to freeze operand read and the earlier stages and to insert a bubble into the first execute stage. The unit re-evaluates the operands every cycle until the value can be delivered.

For coverage, the unit reports on every port which path supplied the operand in that cycle: one of the forwarding paths or the register file.

Top module: `opfwd_unit`

## Requirements
- R1: The path-enable grid `cfg_mask` is captured on every clock edge at which `rst` is high and is held afterwards. A change on `cfg_mask` while `rst` is low has no effect on forwarding or stalling. Bit `p*NSRC+s` enables the path from source `s` to port `p`, and source 0 is the youngest stage.
- R2: When no valid in-flight producer writes the register a port requests, the port returns its register-file value, its flag reads register file and the port causes no stall.
- R3: A request for register 0 returns zero with the register-file flag and never stalls, even if a producer names register 0 as its destination.
- R4: When the youngest matching producer is source `s`, its path to port `p` is enabled and its result is marked ready, port `p` returns that producer's data with flag bit `s` set and causes no stall. For example, a product of 10 held in the second execute stage for R1, added to an R3 of 5 read from the register file, gives operands 10 and 5 and a sum of 15.
- R5: When the youngest matching producer's path to the port is disabled, the unit stalls, even if an older stage holds a matching register on an enabled path.
- R6: When the youngest matching producer's result is not yet marked ready, the unit stalls, even if an older matching stage is ready and enabled.
- R7: Among several valid producers writing the same register, only the youngest one (the lowest source number) is used. Older matches are ignored.
- R8: Each port has an `NSRC+1`-bit flag. Bit `s` means the value was forwarded from source `s`, and bit `NSRC` means it came from the register file. The flag is one-hot when the port does not stall and all zero when it stalls, in which case the port's operand reads zero. `stall` is high exactly when at least one port stalls.
- R9: A stalled dependency clears as soon as its producer reaches a stage whose path to the port is enabled, or once the producer has left the tracked stages and the value comes from the register file.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the path grid is captured while it is high |
| cfg_mask | input | NSRC*NPORT | Path-enable grid, bit p*NSRC+s for source s to port p |
| src_reg | input | NPORT*RW | Requested source register for each operand port |
| rf_data | input | NPORT*DW | Register-file read value for each port |
| prod_vld | input | NSRC | Source stage holds an instruction that writes a register |
| prod_rdy | input | NSRC | Result of the source stage is computed and may be forwarded |
| prod_reg | input | NSRC*RW | Destination register of each source stage |
| prod_data | input | NSRC*DW | Result value of each source stage |
| opnd_data | output | NPORT*DW | Selected operand value per port |
| path_flag | output | NPORT*(NSRC+1) | Per-port one-hot supplier flag, or all zero when the port stalls |
| stall | output | 1 | Hold operand read and earlier stages, bubble into the first execute stage |

## Verification
The assertions check on every cycle that the flags are well formed and agree with each port's stall (R8), that register 0 never stalls or forwards (R3), and that a forwarding flag only appears on an enabled path whose result is ready (R4). They also check that a found producer really matches the request (R7), that a port with no producer never stalls (R2) and that the captured grid stays put after reset (R1). The directed scenarios are needed to show the choices that depend on stage ordering and the grid. These are the stall caused by a removed path even when an older path is usable, waiting for a not-ready result, preferring the youngest writer, the forwarded example sum, and the stall clearing as a producer drains toward write-back.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    localparam int DEF_NSRC  = 3;
    localparam int DEF_NPORT = 2;
    localparam int DEF_RW    = 5;
    localparam int DEF_DW    = 32;
    localparam int IDXW      = 8;

    // Youngest matching producer for one operand port
    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
    } hit_t;

    typedef enum logic [1:0] {
        SEL_RF   = 2'd0,
        SEL_ZERO = 2'd1,
        SEL_FWD  = 2'd2,
        SEL_HOLD = 2'd3
    } sel_e;

    function automatic sel_e choose_sel(logic is_zero, logic hit, logic en, logic rdy);
        if (is_zero)    return SEL_ZERO;
        if (!hit)       return SEL_RF;
        if (en && rdy)  return SEL_FWD;
        return SEL_HOLD;
    endfunction

endpackage

// File: rtl/opfwd_match.sv
module opfwd_match
    import opfwd_pkg::*;
#(
    parameter int NSRC = DEF_NSRC,
    parameter int RW   = DEF_RW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RW-1:0]     src,
    input  logic [NSRC-1:0]   vld,
    input  logic [NSRC*RW-1:0] dst,
    output hit_t              youngest
);

    // Scan oldest to youngest so the lowest source index wins
    always_comb begin
        youngest = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vld[i] && (dst[i*RW +: RW] == src) && (src != '0)) begin
                youngest.hit = 1'b1;
                youngest.idx = IDXW'(i);
            end
        end
    end

    AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (rst)
        youngest.hit |-> (vld[youngest.idx] && src != '0)) else $error("hit without producer"); // R7

endmodule

// File: rtl/opfwd_port_sel.sv
module opfwd_port_sel
    import opfwd_pkg::*;
#(
    parameter int NSRC = DEF_NSRC,
    parameter int RW   = DEF_RW,
    parameter int DW   = DEF_DW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RW-1:0]       src,
    input  hit_t                hit,
    input  logic [NSRC-1:0]     en_row,
    input  logic [NSRC-1:0]     rdy,
    input  logic [NSRC*DW-1:0]  pdata,
    input  logic [DW-1:0]       rf,
    output logic [DW-1:0]       data,
    output logic [NSRC:0]       flag,
    output logic                hold
);

    logic            en_bit;
    logic            rdy_bit;
    logic [DW-1:0]   fdata;
    logic [NSRC-1:0] fwd_oh;
    sel_e            sel;

    always_comb begin
        en_bit  = 1'b0;
        rdy_bit = 1'b0;
        fdata   = '0;
        fwd_oh  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (hit.hit && hit.idx == IDXW'(i)) begin
                en_bit    = en_row[i];
                rdy_bit   = rdy[i];
                fdata     = pdata[i*DW +: DW];
                fwd_oh[i] = 1'b1;
            end
        end
        sel = choose_sel(src == '0, hit.hit, en_bit, rdy_bit);
    end

    always_comb begin
        data = '0;
        flag = '0;
        hold = 1'b0;
        unique case (sel)
            SEL_ZERO: flag[NSRC] = 1'b1;
            SEL_RF: begin
                data       = rf;
                flag[NSRC] = 1'b1;
            end
            SEL_FWD: begin
                data = fdata;
                flag = {1'b0, fwd_oh};
            end
            default: hold = 1'b1;
        endcase
    end

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (data == '0 && flag[NSRC] && !hold)) else $error("r0 misuse"); // R3

    AST_NO_HIT_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit.hit |-> !hold) else $error("stall without producer"); // R2

    AST_FLAG_SHAPE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flag) && (hold == (flag == '0))) else $error("bad flag shape"); // R8

    for (genvar s = 0; s < NSRC; s++) begin : g_fwd_chk
        AST_FWD_LEGAL: assert property (@(posedge clk) disable iff (rst)
            flag[s] |-> (en_row[s] && rdy[s] && data == pdata[s*DW +: DW])) else $error("illegal path"); // R4
    end

endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int NSRC  = DEF_NSRC,
    parameter int NPORT = DEF_NPORT,
    parameter int RW    = DEF_RW,
    parameter int DW    = DEF_DW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSRC*NPORT-1:0]     cfg_mask,
    input  logic [NPORT*RW-1:0]       src_reg,
    input  logic [NPORT*DW-1:0]       rf_data,
    input  logic [NSRC-1:0]           prod_vld,
    input  logic [NSRC-1:0]           prod_rdy,
    input  logic [NSRC*RW-1:0]        prod_reg,
    input  logic [NSRC*DW-1:0]        prod_data,
    output logic [NPORT*DW-1:0]       opnd_data,
    output logic [NPORT*(NSRC+1)-1:0] path_flag,
    output logic                      stall
);

    localparam int FW = NSRC + 1;

    logic [NSRC*NPORT-1:0] cfg_q;
    logic [NPORT-1:0]      port_hold;

    // Grid is captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) cfg_q <= cfg_mask;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        hit_t hit_p;

        opfwd_match #(.NSRC(NSRC), .RW(RW)) u_match (
            .clk      (clk),
            .rst      (rst),
            .src      (src_reg[p*RW +: RW]),
            .vld      (prod_vld),
            .dst      (prod_reg),
            .youngest (hit_p)
        );

        opfwd_port_sel #(.NSRC(NSRC), .RW(RW), .DW(DW)) u_sel (
            .clk    (clk),
            .rst    (rst),
            .src    (src_reg[p*RW +: RW]),
            .hit    (hit_p),
            .en_row (cfg_q[p*NSRC +: NSRC]),
            .rdy    (prod_rdy),
            .pdata  (prod_data),
            .rf     (rf_data[p*DW +: DW]),
            .data   (opnd_data[p*DW +: DW]),
            .flag   (path_flag[p*FW +: FW]),
            .hold   (port_hold[p])
        );

        AST_PORT_STALLS: assert property (@(posedge clk) disable iff (rst)
            (path_flag[p*FW +: FW] == '0) |-> stall) else $error("silent port stall"); // R8
    end

    assign stall = |port_hold;

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_q)) else $error("grid changed after reset"); // R1

endmodule

// File: tb/opfwd_unit_tb_top.sv
module opfwd_unit_tb_top;

    localparam int NSRC  = 3;
    localparam int NPORT = 2;
    localparam int RW    = 5;
    localparam int DW    = 32;
    localparam int FW    = NSRC + 1;
    localparam logic [FW-1:0] F_RF = 4'b1000;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [NSRC*NPORT-1:0]     cfg_mask;
    logic [NPORT*RW-1:0]       src_reg;
    logic [NPORT*DW-1:0]       rf_data;
    logic [NSRC-1:0]           prod_vld;
    logic [NSRC-1:0]           prod_rdy;
    logic [NSRC*RW-1:0]        prod_reg;
    logic [NSRC*DW-1:0]        prod_data;
    logic [NPORT*DW-1:0]       opnd_data;
    logic [NPORT*(NSRC+1)-1:0] path_flag;
    logic                      stall;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    opfwd_unit #(.NSRC(NSRC), .NPORT(NPORT), .RW(RW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .cfg_mask(cfg_mask), .src_reg(src_reg),
        .rf_data(rf_data), .prod_vld(prod_vld), .prod_rdy(prod_rdy),
        .prod_reg(prod_reg), .prod_data(prod_data), .opnd_data(opnd_data),
        .path_flag(path_flag), .stall(stall)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] opnd(input int p);
        return opnd_data[p*DW +: DW];
    endfunction

    function automatic logic [FW-1:0] flg(input int p);
        return path_flag[p*FW +: FW];
    endfunction

    task automatic clear_prod();
        prod_vld = '0; prod_rdy = '0; prod_reg = '0; prod_data = '0;
    endtask

    task automatic set_prod(input int s, input bit v, input bit r, input int rg, input int d);
        prod_vld[s] = v;
        prod_rdy[s] = r;
        prod_reg[s*RW +: RW] = RW'(rg);
        prod_data[s*DW +: DW] = DW'(d);
    endtask

    task automatic set_port(input int p, input int rg, input int d);
        src_reg[p*RW +: RW] = RW'(rg);
        rf_data[p*DW +: DW] = DW'(d);
    endtask

    task automatic step();
        #1;
    endtask

    // Grid: port0 all sources enabled; port1 first execute stage removed
    task automatic t_reset();
        cfg_mask = 6'b110111;
        clear_prod();
        set_port(0, 7, 70);
        set_port(1, 8, 80);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cfg_mask = 6'b111111;   // must be ignored from here on (R1)
        step();
        chk(!stall, "R1 reset idle stall", 64'(stall), 0);
        chk(flg(0) == F_RF && flg(1) == F_RF, "R1 reset flags", 64'(path_flag), {F_RF, F_RF});
    endtask

    task automatic t_no_match();
        @(negedge clk);
        clear_prod();
        set_prod(0, 1, 1, 9, 111);
        set_prod(2, 1, 1, 10, 222);
        set_port(0, 3, 33);
        set_port(1, 4, 44);
        step();
        chk(opnd(0) == 33 && opnd(1) == 44, "R2 rf values", 64'(opnd_data), {32'd44, 32'd33});
        chk(!stall && flg(0) == F_RF && flg(1) == F_RF, "R2 rf flags", 64'(path_flag), {F_RF, F_RF});
    endtask

    task automatic t_zero_reg();
        @(negedge clk);
        clear_prod();
        set_prod(0, 1, 0, 0, 55);   // not ready writer of r0 must not stall
        set_prod(1, 1, 1, 0, 66);
        set_port(0, 0, 123);
        set_port(1, 0, 456);
        step();
        chk(!stall, "R3 r0 no stall", 64'(stall), 0);
        chk(opnd(0) == 0 && opnd(1) == 0, "R3 r0 value", 64'(opnd_data), 0);
        chk(flg(0) == F_RF && flg(1) == F_RF, "R3 r0 flag", 64'(path_flag), {F_RF, F_RF});
    endtask

    task automatic t_fwd_example();
        @(negedge clk);
        clear_prod();
        set_prod(0, 0, 0, 0, 0);      // bubble in first execute stage
        set_prod(1, 1, 1, 1, 2 * 5);  // product for R1 in second execute stage
        set_port(0, 1, 999);
        set_port(1, 3, 5);
        step();
        chk(!stall, "R4 example no stall", 64'(stall), 0);
        chk(opnd(0) + opnd(1) == 15, "R4 example sum", 64'(opnd(0) + opnd(1)), 15);
        chk(flg(0) == 4'b0010 && flg(1) == F_RF, "R4 example flags", 64'(path_flag), {F_RF, 4'b0010});
    endtask

    task automatic t_youngest();
        @(negedge clk);
        clear_prod();
        set_prod(0, 1, 1, 4, 7);
        set_prod(2, 1, 1, 4, 99);
        set_port(0, 4, 1);
        set_port(1, 2, 20);
        step();
        chk(opnd(0) == 7 && flg(0) == 4'b0001, "R7 youngest wins", 64'(opnd(0)), 7);
        chk(!stall, "R7 no stall", 64'(stall), 0);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        clear_prod();
        set_prod(0, 1, 1, 4, 7);     // port1 path removed from this source
        set_prod(1, 1, 1, 4, 8);     // older, enabled: must be ignored
        set_port(0, 2, 20);
        set_port(1, 4, 40);
        step();
        chk(stall, "R5 removed path stalls", 64'(stall), 1);
        chk(flg(1) == 0 && opnd(1) == 0, "R5 stalled port flag", 64'(flg(1)), 0);
        chk(flg(0) == F_RF, "R8 other port flag", 64'(flg(0)), 64'(F_RF));
        chk(stall, "R1 late grid ignored", 64'(stall), 1);
    endtask

    task automatic t_not_ready();
        @(negedge clk);
        clear_prod();
        set_prod(0, 1, 0, 6, 1);
        set_prod(2, 1, 1, 6, 2);
        set_port(0, 6, 3);
        set_port(1, 0, 0);
        step();
        chk(stall && flg(0) == 0, "R6 not ready stalls", 64'(flg(0)), 0);
        @(negedge clk);
        set_prod(0, 1, 1, 6, 61);
        step();
        chk(!stall && opnd(0) == 61 && flg(0) == 4'b0001, "R6 ready forwards", 64'(opnd(0)), 61);
    endtask

    task automatic t_drain();
        @(negedge clk);
        clear_prod();
        set_port(0, 0, 0);
        set_port(1, 4, 0);
        set_prod(0, 1, 1, 4, 44);
        step();
        chk(stall, "R9 stall at first stage", 64'(stall), 1);
        @(negedge clk);
        clear_prod();
        set_prod(1, 1, 1, 4, 44);
        step();
        chk(!stall && opnd(1) == 44 && flg(1) == 4'b0010, "R9 cleared at second stage", 64'(flg(1)), 2);
        @(negedge clk);
        clear_prod();
        set_prod(2, 1, 1, 4, 44);
        step();
        chk(!stall && opnd(1) == 44 && flg(1) == 4'b0100, "R9 writeback path", 64'(flg(1)), 4);
        @(negedge clk);
        clear_prod();
        set_port(1, 4, 44);
        step();
        chk(!stall && opnd(1) == 44 && flg(1) == F_RF, "R9 from register file", 64'(flg(1)), 64'(F_RF));
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        src_reg = '0;
        rf_data = '0;
        cfg_mask = '0;
        clear_prod();
        t_reset();
        t_no_match();
        t_zero_reg();
        t_fwd_example();
        t_youngest();
        t_disabled();
        t_not_ready();
        t_drain();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule